// File: doc/BRIEF.md
# Debug Breakpoint and Watchpoint Hit Qualifier

This block sits after the address comparators of a processor's debug facility. It takes a raw address-match pulse from one instruction breakpoint and from two data watchpoints. It decides, from the current machine state and from each unit's control fields, whether that match should really raise a debug exception. The machine state is three bits: problem (user) state, hypervisor state and data relocation. For each qualified event it reports one of two results. The first is a data-storage exception, which carries the watched address and one status bit. The second is a trace exception, which carries two status bits.

The second watchpoint exists only on newer cores, and a feature input enables it. The block produces one report per cycle. When events collide, watchpoints take precedence. A breakpoint that loses to a watchpoint is kept and reported once no watchpoint qualifies. A second watchpoint that loses to the first is dropped, because both come from the same access. The report is a registered event with a one-cycle latency. It has no back-pressure: the consumer must accept a report in the cycle it is shown.

Top module: `dbg_hit_qualifier`

## Requirements
- R1: After reset, `rpt_valid` is 0, `rpt_kind` is 0, `rpt_status` is 0, `rpt_addr` is 0, and no breakpoint is held over.
- R2: The breakpoint privilege field `bp_priv` is decoded as follows. 0 never matches. 1 matches when `st_prob`=1. 2 matches when `st_prob`=0 and `st_hyp`=0. 3 matches when `st_prob`=0 and `st_hyp`=1.
- R3: The watchpoint control word has these bits: [0] problem enable, [1] supervisor enable, [2] hypervisor enable, [3] ignore translation, [4] translation value. A match is suppressed in three cases: `st_prob`=1 with bit 0 clear, `st_hyp`=1 with bit 2 clear, or bit 1 clear in any state.
- R4: When bit 3 is clear, a watchpoint qualifies only if bit 4 equals `st_drel`. When bit 3 is set, `st_drel` has no effect.
- R5: A watchpoint report has `rpt_kind`=1 and the matching watchpoint's address on `rpt_addr`. `rpt_status` has only bit 41 set, counting from the MSB as bit 0, which is vector index 22.
- R6: A breakpoint report has `rpt_kind`=2 and `rpt_addr`=0. `rpt_status` has only bits 33 and 43 set, counting from the MSB, which are vector indices 30 and 20.
- R7: When `feat_wp1_en`=0, matches on watchpoint 1 have no effect on any output.
- R8: When both watchpoints qualify in the same cycle, watchpoint 0 is reported and the watchpoint 1 event is discarded.
- R9: When a watchpoint and the breakpoint qualify in the same cycle, the watchpoint is reported. The breakpoint is reported in the first later cycle in which no watchpoint qualifies. Further breakpoint hits that arrive while one is held merge into that single report.
- R10: Inputs sampled at a rising edge produce the report after that same edge. `rpt_valid` is 1 exactly when `rpt_kind` is non-zero. When nothing qualifies and nothing is held, the outputs return to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_prob | input | 1 | Machine is in problem state |
| st_hyp | input | 1 | Machine is in hypervisor state |
| st_drel | input | 1 | Data relocation is on |
| feat_wp1_en | input | 1 | Watchpoint 1 is implemented |
| bp_priv | input | 2 | Breakpoint privilege field |
| bp_match | input | 1 | Instruction address matched the breakpoint |
| wp0_ctrl | input | 5 | Watchpoint 0 control word |
| wp0_match | input | 1 | Data address matched watchpoint 0 |
| wp0_addr | input | AW | Data address of the watchpoint 0 match |
| wp1_ctrl | input | 5 | Watchpoint 1 control word |
| wp1_match | input | 1 | Data address matched watchpoint 1 |
| wp1_addr | input | AW | Data address of the watchpoint 1 match |
| rpt_valid | output | 1 | A debug exception is reported this cycle |
| rpt_kind | output | 2 | 0 none, 1 data storage, 2 trace |
| rpt_status | output | 64 | Status bits of the report |
| rpt_addr | output | AW | Address for a data-storage report |

## Verification
The hardest state to reach is a breakpoint held over while watchpoints keep qualifying for several cycles in a row. Reaching it needs a breakpoint hit and a fully enabled watchpoint hit at the same moment, followed by more watchpoint hits before an idle cycle. The stimulus forces this with a directed sequence and also biases random traffic toward enabled control words and frequent matches. Exhaustive sweeps cover every machine state against every watchpoint control word and every breakpoint privilege value.

// File: rtl/dbq_pkg.sv
package dbq_pkg;
  localparam int CTRL_W = 5;
  localparam int STAT_W = 64;
  localparam int NUM_WP = 2;

  localparam int WC_PROB = 0;
  localparam int WC_SUP  = 1;
  localparam int WC_HYP  = 2;
  localparam int WC_XIGN = 3;
  localparam int WC_XVAL = 4;

  localparam int BE_DS_BIT  = 41;
  localparam int BE_TR_BIT0 = 33;
  localparam int BE_TR_BIT1 = 43;

  typedef enum logic [1:0] {
    KIND_NONE   = 2'd0,
    KIND_DSTORE = 2'd1,
    KIND_TRACE  = 2'd2
  } rpt_kind_e;

  typedef struct packed {
    logic prob;
    logic hyp;
    logic drel;
  } mstate_t;

  function automatic logic [STAT_W-1:0] be_mask(input int be_idx);
    logic [STAT_W-1:0] m;
    m = '0;
    m[STAT_W-1-be_idx] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/dbq_wp_qual.sv
module dbq_wp_qual
  import dbq_pkg::*;
(
  input  mstate_t           st,
  input  logic [CTRL_W-1:0] ctrl,
  input  logic              match,
  input  logic              avail,
  output logic              hit
);
  logic priv_ok;
  logic xlat_ok;

  always_comb begin
    if (st.prob && !ctrl[WC_PROB])
      priv_ok = 1'b0;
    else if (st.hyp && !ctrl[WC_HYP])
      priv_ok = 1'b0;
    else
      priv_ok = ctrl[WC_SUP];
  end

  assign xlat_ok = ctrl[WC_XIGN] || (ctrl[WC_XVAL] == st.drel);
  assign hit     = avail && match && priv_ok && xlat_ok;
endmodule

// File: rtl/dbq_bp_qual.sv
module dbq_bp_qual
  import dbq_pkg::*;
(
  input  mstate_t    st,
  input  logic [1:0] priv,
  input  logic       match,
  output logic       hit
);
  logic priv_ok;

  always_comb begin
    unique case (priv)
      2'd1:    priv_ok = st.prob;
      2'd2:    priv_ok = !st.prob && !st.hyp;
      2'd3:    priv_ok = !st.prob && st.hyp;
      default: priv_ok = 1'b0;
    endcase
  end

  assign hit = match && priv_ok;
endmodule

// File: rtl/dbq_report_sel.sv
module dbq_report_sel
  import dbq_pkg::*;
#(
  parameter int AW = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_WP-1:0]   wp_hit,
  input  logic [NUM_WP*AW-1:0] wp_addr,
  input  logic                bp_hit,
  output logic                pend_q,
  output logic                rpt_valid,
  output rpt_kind_e           rpt_kind,
  output logic [STAT_W-1:0]   rpt_status,
  output logic [AW-1:0]       rpt_addr
);
  localparam logic [STAT_W-1:0] DS_MASK = be_mask(BE_DS_BIT);
  localparam logic [STAT_W-1:0] TR_MASK = be_mask(BE_TR_BIT0) | be_mask(BE_TR_BIT1);

  logic [AW-1:0] sel_addr;
  logic          wp_any;
  logic          bp_any;

  always_comb begin
    sel_addr = '0;
    for (int i = NUM_WP - 1; i >= 0; i--) begin
      if (wp_hit[i]) sel_addr = wp_addr[i*AW +: AW];
    end
  end

  assign wp_any = |wp_hit;
  assign bp_any = bp_hit || pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q     <= 1'b0;
      rpt_valid  <= 1'b0;
      rpt_kind   <= KIND_NONE;
      rpt_status <= '0;
      rpt_addr   <= '0;
    end else if (wp_any) begin
      pend_q     <= bp_any;
      rpt_valid  <= 1'b1;
      rpt_kind   <= KIND_DSTORE;
      rpt_status <= DS_MASK;
      rpt_addr   <= sel_addr;
    end else if (bp_any) begin
      pend_q     <= 1'b0;
      rpt_valid  <= 1'b1;
      rpt_kind   <= KIND_TRACE;
      rpt_status <= TR_MASK;
      rpt_addr   <= '0;
    end else begin
      pend_q     <= 1'b0;
      rpt_valid  <= 1'b0;
      rpt_kind   <= KIND_NONE;
      rpt_status <= '0;
      rpt_addr   <= '0;
    end
  end
endmodule

// File: rtl/dbg_hit_qualifier.sv
module dbg_hit_qualifier
  import dbq_pkg::*;
#(
  parameter int AW = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              st_prob,
  input  logic              st_hyp,
  input  logic              st_drel,
  input  logic              feat_wp1_en,
  input  logic [1:0]        bp_priv,
  input  logic              bp_match,
  input  logic [4:0]        wp0_ctrl,
  input  logic              wp0_match,
  input  logic [AW-1:0]     wp0_addr,
  input  logic [4:0]        wp1_ctrl,
  input  logic              wp1_match,
  input  logic [AW-1:0]     wp1_addr,
  output logic              rpt_valid,
  output logic [1:0]        rpt_kind,
  output logic [63:0]       rpt_status,
  output logic [AW-1:0]     rpt_addr
);
  mstate_t                st;
  logic [NUM_WP*CTRL_W-1:0] wp_ctrl;
  logic [NUM_WP-1:0]      wp_match;
  logic [NUM_WP-1:0]      wp_avail;
  logic [NUM_WP-1:0]      wp_hit;
  logic [NUM_WP*AW-1:0]   wp_addr;
  logic                   bp_hit;
  logic                   pend_q;
  rpt_kind_e              kind_q;

  assign st       = '{prob: st_prob, hyp: st_hyp, drel: st_drel};
  assign wp_ctrl  = {wp1_ctrl, wp0_ctrl};
  assign wp_match = {wp1_match, wp0_match};
  assign wp_addr  = {wp1_addr, wp0_addr};
  assign wp_avail = {feat_wp1_en, 1'b1};

  for (genvar g = 0; g < NUM_WP; g++) begin : g_wp
    dbq_wp_qual u_wp (
      .st    (st),
      .ctrl  (wp_ctrl[g*CTRL_W +: CTRL_W]),
      .match (wp_match[g]),
      .avail (wp_avail[g]),
      .hit   (wp_hit[g])
    );
  end

  dbq_bp_qual u_bp (
    .st    (st),
    .priv  (bp_priv),
    .match (bp_match),
    .hit   (bp_hit)
  );

  dbq_report_sel #(.AW(AW)) u_sel (
    .clk        (clk),
    .rst_n      (rst_n),
    .wp_hit     (wp_hit),
    .wp_addr    (wp_addr),
    .bp_hit     (bp_hit),
    .pend_q     (pend_q),
    .rpt_valid  (rpt_valid),
    .rpt_kind   (kind_q),
    .rpt_status (rpt_status),
    .rpt_addr   (rpt_addr)
  );

  assign rpt_kind = kind_q;
endmodule

// File: rtl/dbg_hit_qualifier_chk.sv
module dbg_hit_qualifier_chk #(
  parameter int AW = 64
) (
  input logic          clk,
  input logic          rst_n,
  input logic          feat_wp1_en,
  input logic [1:0]    bp_priv,
  input logic [4:0]    wp0_ctrl,
  input logic          wp0_match,
  input logic          wp1_match,
  input logic          pend_q,
  input logic          rpt_valid,
  input logic [1:0]    rpt_kind,
  input logic [63:0]   rpt_status,
  input logic [AW-1:0] rpt_addr
);
  AST_NO_DSTORE_WHEN_WP1_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!feat_wp1_en && !wp0_match) |=> (rpt_kind != 2'd1)); // R7

  AST_SV_CLEAR_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (wp0_match && !wp0_ctrl[1] && !(feat_wp1_en && wp1_match)) |=> (rpt_kind != 2'd1)); // R3

  AST_DSTORE_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    (rpt_kind == 2'd1) |-> (rpt_status == 64'h0000_0000_0040_0000)); // R5

  AST_TRACE_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    (rpt_kind == 2'd2) |-> (rpt_status == 64'h0000_0000_4010_0000 && rpt_addr == '0)); // R6

  AST_PRIV_ZERO_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (bp_priv == 2'd0 && !pend_q) |=> (rpt_kind != 2'd2)); // R2

  AST_VALID_MATCHES_KIND: assert property (@(posedge clk) disable iff (!rst_n)
    rpt_valid == (rpt_kind != 2'd0)); // R10

  AST_HELD_BP_REPORTED: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && $past(rpt_kind) == 2'd1) |-> (rpt_kind == 2'd1)); // R9
endmodule

bind dbg_hit_qualifier dbg_hit_qualifier_chk #(.AW(AW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .feat_wp1_en (feat_wp1_en),
  .bp_priv     (bp_priv),
  .wp0_ctrl    (wp0_ctrl),
  .wp0_match   (wp0_match),
  .wp1_match   (wp1_match),
  .pend_q      (pend_q),
  .rpt_valid   (rpt_valid),
  .rpt_kind    (rpt_kind),
  .rpt_status  (rpt_status),
  .rpt_addr    (rpt_addr)
);

// File: tb/test_dbg_hit_qualifier.sv
module test_dbg_hit_qualifier;
  localparam int AW = 64;
  localparam logic [63:0] DS_STAT = 64'h0000_0000_0040_0000;
  localparam logic [63:0] TR_STAT = 64'h0000_0000_4010_0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic st_prob = 0, st_hyp = 0, st_drel = 0, feat_wp1_en = 0;
  logic [1:0] bp_priv = 0;
  logic bp_match = 0;
  logic [4:0] wp0_ctrl = 0, wp1_ctrl = 0;
  logic wp0_match = 0, wp1_match = 0;
  logic [AW-1:0] wp0_addr = 0, wp1_addr = 0;
  logic rpt_valid;
  logic [1:0] rpt_kind;
  logic [63:0] rpt_status;
  logic [AW-1:0] rpt_addr;

  int checks = 0;
  int errors = 0;
  bit m_pend = 0;

  always #2 clk = ~clk;

  dbg_hit_qualifier #(.AW(AW)) i_dbg_hit_qualifier (
    .clk(clk), .rst_n(rst_n), .st_prob(st_prob), .st_hyp(st_hyp), .st_drel(st_drel),
    .feat_wp1_en(feat_wp1_en), .bp_priv(bp_priv), .bp_match(bp_match),
    .wp0_ctrl(wp0_ctrl), .wp0_match(wp0_match), .wp0_addr(wp0_addr),
    .wp1_ctrl(wp1_ctrl), .wp1_match(wp1_match), .wp1_addr(wp1_addr),
    .rpt_valid(rpt_valid), .rpt_kind(rpt_kind), .rpt_status(rpt_status), .rpt_addr(rpt_addr)
  );

  function automatic bit ref_wp(bit p, bit h, bit d, logic [4:0] c, bit m, bit av);
    bit ok;
    if (!m || !av) return 0;
    ok = c[1];
    if (p && !c[0]) ok = 0;
    if (h && !c[2]) ok = 0;
    if (!c[3] && (c[4] != d)) ok = 0;
    return ok;
  endfunction

  function automatic bit ref_bp(bit p, bit h, logic [1:0] pr, bit m);
    case (pr)
      2'd1: return m && p;
      2'd2: return m && !p && !h;
      2'd3: return m && !p && h;
      default: return 0;
    endcase
  endfunction

  task automatic check_out(string tag, bit ev, logic [1:0] ek, logic [63:0] es, logic [AW-1:0] ea);
    checks++;
    if (rpt_valid !== ev || rpt_kind !== ek || rpt_status !== es || rpt_addr !== ea) begin
      errors++;
      $display("FAIL %s: got v=%0b k=%0d s=%h a=%h, expected v=%0b k=%0d s=%h a=%h",
               tag, rpt_valid, rpt_kind, rpt_status, rpt_addr, ev, ek, es, ea);
    end
  endtask

  // Inputs are set at a falling edge; predict, cross one rising edge, check at the next falling edge.
  task automatic step(string tag);
    bit w0, w1, b, bp_any, ev;
    logic [1:0] ek;
    logic [63:0] es;
    logic [AW-1:0] ea;
    w0 = ref_wp(st_prob, st_hyp, st_drel, wp0_ctrl, wp0_match, 1'b1);
    w1 = ref_wp(st_prob, st_hyp, st_drel, wp1_ctrl, wp1_match, feat_wp1_en);
    b  = ref_bp(st_prob, st_hyp, bp_priv, bp_match);
    bp_any = b || m_pend;
    if (w0 || w1) begin
      ev = 1; ek = 2'd1; es = DS_STAT; ea = w0 ? wp0_addr : wp1_addr; m_pend = bp_any;
    end else if (bp_any) begin
      ev = 1; ek = 2'd2; es = TR_STAT; ea = '0; m_pend = 0;
    end else begin
      ev = 0; ek = 2'd0; es = '0; ea = '0; m_pend = 0;
    end
    @(posedge clk);
    @(negedge clk);
    check_out(tag, ev, ek, es, ea);
  endtask

  task automatic idle_inputs();
    bp_match = 0; wp0_match = 0; wp1_match = 0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #800_000;
    checks++; errors++;
    $display("FAIL R10: watchdog expired, got hang, expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check_out("R1", 0, 2'd0, '0, '0);
    rst_n = 1;
    step("R1");

    // R3: every machine state against every control word, watchpoint 0
    for (int s = 0; s < 8; s++) begin
      for (int c = 0; c < 32; c++) begin
        {st_prob, st_hyp, st_drel} = s[2:0];
        wp0_ctrl = c[4:0]; wp0_match = 1; wp0_addr = {32'hA5A5_0000, 24'd0, s[2:0], c[4:0]};
        step("R3");
      end
    end
    idle_inputs(); step("R3");

    // R4: translation check with privilege enables all on
    for (int d = 0; d < 2; d++) begin
      for (int x = 0; x < 4; x++) begin
        st_prob = 0; st_hyp = 0; st_drel = d[0];
        wp0_ctrl = {x[1:0], 3'b111}; wp0_match = 1;
        step("R4");
      end
    end
    idle_inputs(); step("R4");

    // R2: breakpoint privilege decode in every state
    for (int s = 0; s < 4; s++) begin
      for (int p = 0; p < 4; p++) begin
        {st_prob, st_hyp} = s[1:0]; bp_priv = p[1:0]; bp_match = 1;
        step("R2");
        bp_match = 0; step("R2");
      end
    end

    // R5: specific watchpoint report
    st_prob = 0; st_hyp = 1; st_drel = 1; wp0_ctrl = 5'b01110; wp0_match = 1;
    wp0_addr = 64'hDEAD_BEEF_0123_4568;
    step("R5");
    idle_inputs(); step("R5");

    // R6: hypervisor breakpoint
    st_prob = 0; st_hyp = 1; bp_priv = 2'd3; bp_match = 1;
    step("R6");
    idle_inputs(); step("R6");

    // R7: watchpoint 1 without the feature
    feat_wp1_en = 0; wp1_ctrl = 5'b01111; wp1_match = 1; wp1_addr = 64'h1111_2222_3333_4440;
    step("R7");
    idle_inputs(); step("R7");
    feat_wp1_en = 1; wp1_match = 1;
    step("R7");
    idle_inputs(); step("R7");

    // R8: both watchpoints qualify
    wp0_ctrl = 5'b01111; wp0_match = 1; wp0_addr = 64'h0000_0000_0000_1000;
    wp1_ctrl = 5'b01111; wp1_match = 1; wp1_addr = 64'h0000_0000_0000_2000;
    step("R8");
    idle_inputs(); step("R8");

    // R9: breakpoint collides with watchpoints for several cycles
    st_prob = 0; st_hyp = 0; bp_priv = 2'd2; bp_match = 1;
    wp0_ctrl = 5'b01111; wp0_match = 1;
    step("R9");
    bp_match = 0; step("R9");
    bp_match = 1; step("R9");
    idle_inputs(); step("R9");
    step("R9");

    // R10: random traffic biased toward enabled words and frequent matches
    for (int n = 0; n < 4000; n++) begin
      {st_prob, st_hyp, st_drel} = 3'($urandom);
      feat_wp1_en = ($urandom % 4) != 0;
      bp_priv  = 2'($urandom);
      bp_match = ($urandom % 3) == 0;
      wp0_ctrl = ($urandom % 2) ? 5'($urandom) | 5'b00111 : 5'($urandom);
      wp1_ctrl = ($urandom % 2) ? 5'($urandom) | 5'b00111 : 5'($urandom);
      wp0_match = ($urandom % 3) == 0;
      wp1_match = ($urandom % 3) == 0;
      wp0_addr = {$urandom, $urandom};
      wp1_addr = {$urandom, $urandom};
      step("R10");
    end
    idle_inputs(); step("R10");
    step("R10");

    // R1: reset mid-stream clears held breakpoint
    bp_priv = 2'd2; st_prob = 0; st_hyp = 0; bp_match = 1; wp0_ctrl = 5'b01111; wp0_match = 1;
    step("R1");
    rst_n = 0; idle_inputs();
    @(posedge clk); @(negedge clk);
    m_pend = 0;
    check_out("R1", 0, 2'd0, '0, '0);
    rst_n = 1;
    step("R1");

    finish_run();
  end
endmodule